// File: doc/BRIEF.md
# Segment-Steered Data Memory Port Router

This block sits between a core's data memory request path and two external bus ports, called A and B. The 32-bit data address space is divided into eight equal segments, and the segment number is the top three address bits. A control word that software can write holds one steering bit for each segment. Every request the core issues goes out on exactly one port: port A when the segment's bit is clear, port B when it is set. The response for that request comes back through the same port.

Requests are handled one at a time by a three-state controller:
- **IDLE** accepts a request (transition ACCEPT to ISSUE). On ACCEPT it latches the address, write flag, write data and the chosen port.
- **ISSUE** presents the latched request on the chosen port only. When that port signals ready it moves to WAIT (transition HANDOFF).
- **WAIT** passes the chosen port's response back to the core. When the response arrives it returns to IDLE (transition COMPLETE).

Reads and writes both finish with exactly one response beat. The data in a write's response is don't-care.

The control word is 32 bits wide:

| Bits | Contents | Behaviour |
|------|----------|-----------|
| 15:0 | General storage | Read/write. No effect on routing. |
| 23:16 | Steering bits | Bit 16+s steers segment s. |
| 31:24 | Reserved | Always read as zero. |

Top module: `seg_port_router`

## Requirements
- R1: The segment of a request is req_addr[31:29]. Control bit 16+segment selects the port: 0 gives port A, 1 gives port B. For example, with only bit 20 set, 0x7FFFFFFC and 0xA0000000 go to A, while 0x80000000 and 0x9FFFFFFC go to B.
- R2: After reset, cfg_rdata reads 0x00000000, req_ready is 1, no port valid or core response is asserted, and every segment routes to port A.
- R3: cfg_rdata[31:24] always reads zero, whatever value was written to those bits.
- R4: cfg_rdata[15:0] returns the last value written to bits 15:0, and those bits have no effect on which port is chosen.
- R5: In ISSUE, exactly one of pa_req_valid and pb_req_valid is high, never both. The address, write flag and write data presented on the ports equal those of the accepted request.
- R6: The port is fixed at ACCEPT. A control write made while the request is in ISSUE or WAIT does not reroute that request, but it does govern later requests.
- R7: req_ready is high only in IDLE. While the chosen port holds its ready low, the request stays valid and unchanged on that port and no new core request is accepted.
- R8: In WAIT, rsp_valid and rsp_rdata follow only the chosen port's response inputs. The other port's response inputs are ignored. After COMPLETE, req_ready is high again.
- R9: cfg_rdata shows a written value from the clock cycle after cfg_we is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write value |
| cfg_rdata | output | 32 | Control word readback |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Core request accepted (IDLE) |
| req_addr | input | 32 | Core request address |
| req_we | input | 1 | Core request is a write |
| req_wdata | input | 32 | Core write data |
| rsp_valid | output | 1 | Response beat to core |
| rsp_rdata | output | 32 | Response data to core |
| pa_req_valid | output | 1 | Port A request valid |
| pa_req_ready | input | 1 | Port A takes request |
| pa_addr | output | 32 | Port A address |
| pa_we | output | 1 | Port A write flag |
| pa_wdata | output | 32 | Port A write data |
| pa_rsp_valid | input | 1 | Port A response valid |
| pa_rsp_rdata | input | 32 | Port A response data |
| pb_req_valid | output | 1 | Port B request valid |
| pb_req_ready | input | 1 | Port B takes request |
| pb_addr | output | 32 | Port B address |
| pb_we | output | 1 | Port B write flag |
| pb_wdata | output | 32 | Port B write data |
| pb_rsp_valid | input | 1 | Port B response valid |
| pb_rsp_rdata | input | 32 | Port B response data |

## Verification
A wrong steering bit, or a segment decoded from the wrong address bits, shows up one cycle after ACCEPT: the valid strobe appears on the wrong port. The bench drives distinct response data on both ports, so a wrong latched route is also visible in the WAIT cycle as the wrong rsp_rdata. A controller stuck outside IDLE shows as req_ready staying low on the next request. A reserved bit or general bit mis-stored shows on cfg_rdata in the cycle right after the write.

// File: rtl/seg_router_pkg.sv
package seg_router_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } router_state_e;

endpackage

// File: rtl/seg_router_cfg.sv
module seg_router_cfg #(
    parameter int DATA_W  = 32,
    parameter int SEL_LSB = 16,
    parameter int NUM_SEG = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [NUM_SEG-1:0] seg_sel
);
    localparam int RSV_LSB = SEL_LSB + NUM_SEG;
    localparam int RSV_W   = DATA_W - RSV_LSB;

    logic [SEL_LSB-1:0] gp_q;
    logic [NUM_SEG-1:0] sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gp_q  <= '0;
            sel_q <= '0;
        end else if (we) begin
            gp_q  <= wdata[SEL_LSB-1:0];
            sel_q <= wdata[RSV_LSB-1:SEL_LSB];
        end
    end

    generate
        if (RSV_W > 0) begin : g_rsv
            assign rdata = {{RSV_W{1'b0}}, sel_q, gp_q};
        end else begin : g_full
            assign rdata = {sel_q, gp_q};
        end
    endgenerate

    assign seg_sel = sel_q;

    // R9: a write is visible on the next cycle
    p_write_visible_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rdata[RSV_LSB-1:0] == $past(wdata[RSV_LSB-1:0]));

    // R6: steering bits change only through a write
    p_sel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(seg_sel));

endmodule

// File: rtl/seg_router_decode.sv
module seg_router_decode #(
    parameter int SEG_BITS = 3,
    parameter int NUM_SEG  = 8
) (
    input  logic [SEG_BITS-1:0] seg_idx,
    input  logic [NUM_SEG-1:0]  seg_sel,
    output logic [NUM_SEG-1:0]  seg_hit,
    output logic                route_b
);
    genvar s;
    generate
        for (s = 0; s < NUM_SEG; s++) begin : g_seg
            assign seg_hit[s] = (seg_idx == SEG_BITS'(s));
        end
    endgenerate

    assign route_b = |(seg_hit & seg_sel);

endmodule

// File: rtl/seg_router_fsm.sv
module seg_router_fsm
    import seg_router_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              route_b,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              pa_req_valid,
    input  logic              pa_req_ready,
    input  logic              pa_rsp_valid,
    input  logic [DATA_W-1:0] pa_rsp_rdata,
    output logic              pb_req_valid,
    input  logic              pb_req_ready,
    input  logic              pb_rsp_valid,
    input  logic [DATA_W-1:0] pb_rsp_rdata,
    output logic [ADDR_W-1:0] port_addr,
    output logic              port_we,
    output logic [DATA_W-1:0] port_wdata
);
    router_state_e state_q, state_d;
    logic              route_q;
    logic [ADDR_W-1:0] addr_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic              sel_ready;
    logic              sel_rsp;

    assign sel_ready = route_q ? pb_req_ready : pa_req_ready;
    assign sel_rsp   = route_q ? pb_rsp_valid : pa_rsp_valid;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request capture at ACCEPT
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_q <= 1'b0;
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (state_q == ST_IDLE && req_valid) begin
            route_q <= route_b;
            addr_q  <= req_addr;
            we_q    <= req_we;
            wdata_q <= req_wdata;
        end
    end

    // transitions: ACCEPT, HANDOFF, COMPLETE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = ST_ISSUE;
            ST_ISSUE: if (sel_ready) state_d = ST_WAIT;
            ST_WAIT:  if (sel_rsp)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        pa_req_valid = 1'b0;
        pb_req_valid = 1'b0;
        rsp_valid    = 1'b0;
        rsp_rdata    = '0;
        unique case (state_q)
            ST_IDLE:  req_ready = 1'b1;
            ST_ISSUE: begin
                pa_req_valid = !route_q;
                pb_req_valid = route_q;
            end
            ST_WAIT: begin
                rsp_valid = sel_rsp;
                rsp_rdata = route_q ? pb_rsp_rdata : pa_rsp_rdata;
            end
            default: ;
        endcase
    end

    assign port_addr  = addr_q;
    assign port_we    = we_q;
    assign port_wdata = wdata_q;

    p_one_port_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pa_req_valid && pb_req_valid));

    p_accept_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (pa_req_valid || pb_req_valid) && port_addr == $past(req_addr));

    p_hold_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pa_req_valid && !pa_req_ready) |=> pa_req_valid && $stable(port_addr) && !req_ready);

    p_hold_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pb_req_valid && !pb_req_ready) |=> pb_req_valid && $stable(port_addr) && !req_ready);

    p_route_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE) |=> $stable(route_q));

    p_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> req_ready);

endmodule

// File: rtl/seg_port_router.sv
module seg_port_router #(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int SEG_BITS = 3,
    parameter int SEL_LSB  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_we,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              pa_req_valid,
    input  logic              pa_req_ready,
    output logic [ADDR_W-1:0] pa_addr,
    output logic              pa_we,
    output logic [DATA_W-1:0] pa_wdata,
    input  logic              pa_rsp_valid,
    input  logic [DATA_W-1:0] pa_rsp_rdata,
    output logic              pb_req_valid,
    input  logic              pb_req_ready,
    output logic [ADDR_W-1:0] pb_addr,
    output logic              pb_we,
    output logic [DATA_W-1:0] pb_wdata,
    input  logic              pb_rsp_valid,
    input  logic [DATA_W-1:0] pb_rsp_rdata
);
    localparam int NUM_SEG = 1 << SEG_BITS;

    logic [NUM_SEG-1:0] seg_sel;
    logic [NUM_SEG-1:0] seg_hit;
    logic [SEG_BITS-1:0] seg_idx;
    logic               route_b;
    logic [ADDR_W-1:0]  port_addr;
    logic               port_we;
    logic [DATA_W-1:0]  port_wdata;

    assign seg_idx = req_addr[ADDR_W-1 -: SEG_BITS];

    seg_router_cfg #(
        .DATA_W (DATA_W),
        .SEL_LSB(SEL_LSB),
        .NUM_SEG(NUM_SEG)
    ) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .wdata  (cfg_wdata),
        .rdata  (cfg_rdata),
        .seg_sel(seg_sel)
    );

    seg_router_decode #(
        .SEG_BITS(SEG_BITS),
        .NUM_SEG (NUM_SEG)
    ) u_dec (
        .seg_idx(seg_idx),
        .seg_sel(seg_sel),
        .seg_hit(seg_hit),
        .route_b(route_b)
    );

    seg_router_fsm #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_we      (req_we),
        .req_wdata   (req_wdata),
        .route_b     (route_b),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .pa_req_valid(pa_req_valid),
        .pa_req_ready(pa_req_ready),
        .pa_rsp_valid(pa_rsp_valid),
        .pa_rsp_rdata(pa_rsp_rdata),
        .pb_req_valid(pb_req_valid),
        .pb_req_ready(pb_req_ready),
        .pb_rsp_valid(pb_rsp_valid),
        .pb_rsp_rdata(pb_rsp_rdata),
        .port_addr   (port_addr),
        .port_we     (port_we),
        .port_wdata  (port_wdata)
    );

    assign pa_addr  = port_addr;
    assign pa_we    = port_we;
    assign pa_wdata = port_wdata;
    assign pb_addr  = port_addr;
    assign pb_we    = port_we;
    assign pb_wdata = port_wdata;

    p_seg_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_hit) == 1);

    p_route_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> pb_req_valid == $past(seg_sel[seg_idx]));

endmodule

// File: tb/seg_port_router_test.sv
`timescale 1ns/1ps
module seg_port_router_test;

    localparam logic [31:0] TAG_A = 32'hA0A0_5151;
    localparam logic [31:0] TAG_B = 32'hB0B0_6262;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        pa_req_valid, pb_req_valid;
    logic        pa_req_ready = 1'b1, pb_req_ready = 1'b1;
    logic [31:0] pa_addr, pb_addr, pa_wdata, pb_wdata;
    logic        pa_we, pb_we;
    logic        pa_rsp_valid = 1'b0, pb_rsp_valid = 1'b0;
    logic [31:0] pa_rsp_rdata = '0, pb_rsp_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    seg_port_router uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .pa_req_valid(pa_req_valid), .pa_req_ready(pa_req_ready), .pa_addr(pa_addr),
        .pa_we(pa_we), .pa_wdata(pa_wdata), .pa_rsp_valid(pa_rsp_valid), .pa_rsp_rdata(pa_rsp_rdata),
        .pb_req_valid(pb_req_valid), .pb_req_ready(pb_req_ready), .pb_addr(pb_addr),
        .pb_we(pb_we), .pb_wdata(pb_wdata), .pb_rsp_valid(pb_rsp_valid), .pb_rsp_rdata(pb_rsp_rdata)
    );

    // control write value, expected readback
    localparam logic [31:0] VEC_WR [8] = '{
        32'hA5C3_1234, 32'h0000_0000, 32'hFF5A_FFFF, 32'hFF00_FFFF,
        32'h0080_BEEF, 32'h7E3C_0F0F, 32'hFFFF_FFFF, 32'h0010_0001 };
    localparam logic [31:0] VEC_RB [8] = '{
        32'h00C3_1234, 32'h0000_0000, 32'h005A_FFFF, 32'h0000_FFFF,
        32'h0080_BEEF, 32'h003C_0F0F, 32'h00FF_FFFF, 32'h0010_0001 };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_cfg(input logic [31:0] val);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = val;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_access(input logic [31:0] addr, input bit exp_b, input int stall,
                              input bit mid_wr, input logic [31:0] mid_val);
        logic [31:0] exp_data;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        req_we    = addr[2];
        req_wdata = ~addr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp_b) pb_req_ready = (stall == 0);
        else       pa_req_ready = (stall == 0);
        if (mid_wr) begin
            cfg_we = 1'b1;
            cfg_wdata = mid_val;
        end
        #1;
        check(pa_req_valid == !exp_b && pb_req_valid == exp_b, "R1 R5 port choice",
              {30'd0, pb_req_valid, pa_req_valid}, {30'd0, exp_b, !exp_b});
        check(pa_addr == addr && pb_addr == addr && pa_we == addr[2] && pa_wdata == ~addr,
              "R5 forwarded request", pa_addr, addr);
        check(req_ready == 1'b0, "R7 busy in issue", {31'd0, req_ready}, 32'd0);
        for (int k = 0; k < stall; k++) begin
            @(posedge clk);
            @(negedge clk);
            cfg_we = 1'b0;
            #1;
            check(pa_req_valid == !exp_b && pb_req_valid == exp_b && pa_addr == addr && !req_ready,
                  "R6 R7 held on chosen port", {30'd0, pb_req_valid, pa_req_valid}, {30'd0, exp_b, !exp_b});
        end
        pa_req_ready = 1'b1;
        pb_req_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        pa_rsp_valid = 1'b1;
        pb_rsp_valid = 1'b1;
        pa_rsp_rdata = addr ^ TAG_A;
        pb_rsp_rdata = addr ^ TAG_B;
        exp_data = exp_b ? (addr ^ TAG_B) : (addr ^ TAG_A);
        #1;
        check(rsp_valid && rsp_rdata == exp_data && !pa_req_valid && !pb_req_valid,
              "R8 response from chosen port", rsp_rdata, exp_data);
        @(posedge clk);
        @(negedge clk);
        pa_rsp_valid = 1'b0;
        pb_rsp_valid = 1'b0;
        #1;
        check(req_ready == 1'b1, "R8 back to idle", {31'd0, req_ready}, 32'd1);
    endtask

    task automatic summary;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R2 reset state
        check(cfg_rdata == 32'd0, "R2 reset readback", cfg_rdata, 32'd0);
        check(req_ready && !pa_req_valid && !pb_req_valid && !rsp_valid, "R2 reset outputs",
              {28'd0, req_ready, pa_req_valid, pb_req_valid, rsp_valid}, 32'h8);
        for (int s = 0; s < 8; s++)
            run_access({s[2:0], 29'h0000_0040}, 1'b0, 0, 1'b0, 32'd0);   // R2 all to A

        // table walk: R1 R3 R4 R9
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            cfg_we = 1'b1;
            cfg_wdata = VEC_WR[v];
            @(negedge clk);
            cfg_we = 1'b0;
            #1;
            check(cfg_rdata == VEC_RB[v], "R3 R4 R9 readback", cfg_rdata, VEC_RB[v]);
            for (int s = 0; s < 8; s++)
                run_access({s[2:0], 29'(v * 32'h1111 + s * 4)}, VEC_RB[v][16 + s], 0, 1'b0, 32'd0);
        end

        // R1 segment 4 boundaries
        write_cfg(32'h0010_0000);
        run_access(32'h7FFF_FFFC, 1'b0, 0, 1'b0, 32'd0);
        run_access(32'h8000_0000, 1'b1, 0, 1'b0, 32'd0);
        run_access(32'h9FFF_FFFC, 1'b1, 0, 1'b0, 32'd0);
        run_access(32'hA000_0000, 1'b0, 0, 1'b0, 32'd0);

        // R6 write in flight does not reroute; R7 stall on port B
        write_cfg(32'h0002_0000);
        run_access(32'h2000_0010, 1'b1, 3, 1'b1, 32'h0000_0000);
        #1;
        check(cfg_rdata == 32'd0, "R6 in-flight write landed", cfg_rdata, 32'd0);
        run_access(32'h2000_0014, 1'b0, 0, 1'b0, 32'd0);        // R6 later request follows new value
        // R7 stall on port A, in-flight write sets the segment
        run_access(32'h2000_0018, 1'b0, 2, 1'b1, 32'h0002_0000);
        run_access(32'h2000_001C, 1'b1, 0, 1'b0, 32'd0);

        // R3 reserved bits ignored alone
        write_cfg(32'hFF00_0000);
        #1;
        check(cfg_rdata == 32'd0, "R3 reserved write ignored", cfg_rdata, 32'd0);
        run_access(32'hE000_0000, 1'b0, 0, 1'b0, 32'd0);

        summary();
    end

endmodule